// File: doc/BRIEF.md
# Multicart Outer Bank Wrapper

This block turns the inner program and character bank numbers from a bank-switching mapper core into the final bank numbers for a cartridge that holds several games. Four 8-bit outer registers set which slice of program and character memory the running game may reach. A menu program writes them before it starts a game. The bank path is purely combinational: the outer registers mask the inner numbers and then place them in the selected slice. Only the register file, its write pointer and the lock state are clocked.

All four registers share one CPU write window, 0x6000 to 0x7FFF. A 2-bit rolling pointer picks the target of each write and advances by one after it. A write that puts bit 6 into the fourth register locks the block. From then until reset, writes to the window are ignored. Reads from the window are not handled here.

The write control is a two-state machine. `WIN_OPEN` is the reset state, in which window writes are taken. `WIN_LOCKED` ignores every write. The transitions are:
- `WIN_OPEN` to `WIN_LOCKED`: a taken write while the pointer is 3 and data bit 6 is 1.
- `WIN_OPEN` to `WIN_OPEN`: any other cycle.
- `WIN_LOCKED` to `WIN_LOCKED`: every cycle until reset.
- Either state to `WIN_OPEN`: reset.

Top module: `mc_outer_bank`

## Requirements
- R1: A write with `cpu_wr` high and `cpu_addr` in 0x6000..0x7FFF, while unlocked, stores `cpu_data` into the outer register selected by the 2-bit pointer. The pointer then steps by one, from 3 back to 0. Slot 0 is the character base, slot 1 the program base, slot 2 the character control and slot 3 the program control.
- R2: A write whose address is outside 0x6000..0x7FFF changes neither any outer register nor the pointer.
- R3: Once a taken write into slot 3 has data bit 6 set, later window writes change no register and do not move the pointer, until reset.
- R4: Reset (`rst_n` low, synchronous) clears all four outer registers, the pointer and the lock. Afterwards `prg_out` = `prg_in` & 0x3F and `chr_out` = `chr_in` & 0x001.
- R5: The character bank keeps only the low (slot2[2:0] + 1) bits of `chr_in`; its other low 8 bits are cleared before the OR of R6.
- R6: `chr_out[7:0]` is the masked character bank ORed with slot 0, and `chr_out[8]` equals bit 4 of slot 2.
- R7: The program bank is `prg_in` ANDed with the inverse of slot3[5:0], with bits 7:6 cleared.
- R8: `prg_out` is the masked program bank of R7 ORed with slot 1.
- R9: Both outputs follow `prg_in` and `chr_in` in the same cycle, with no register on the bank path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| prg_in | input | 8 | Inner program bank number from the mapper core |
| chr_in | input | 8 | Inner character bank number from the mapper core |
| prg_out | output | 8 | Final program bank number |
| chr_out | output | 9 | Final character bank number |

## Verification
On every cycle, the assertions check these properties:
- the pointer steps after each taken write;
- out-of-window writes leave the pointer alone;
- the locked state freezes the pointer and never leaves;
- reset clears the pointer and the lock;
- the final banks always carry the slot 1 base and the slot 2 high bit.

Only the bench's scenarios can show the rest:
- data lands in the right slot in write order;
- the character mask width follows all eight settings of the control field;
- the program mask clears exactly the chosen bits;
- writes made after the lock really leave the outputs unchanged.

// File: rtl/mc_outer_bank_pkg.sv
package mc_outer_bank_pkg;

    // Width of one outer register and of one inner bank number
    localparam int OB_W = 8;

    // Number of outer registers, and the bits of the write pointer
    localparam int OB_SLOTS = 4;
    localparam int OB_IDX_W = $clog2(OB_SLOTS);

    // Bit positions inside the control slots
    localparam int OB_LOCK_BIT  = 6;
    localparam int OB_PRG_MSK_W = 6;
    localparam int OB_CHR_SEL_W = 3;
    localparam int OB_CHR_HI    = 4;

    // Slot roles
    localparam int SLOT_CHR_BASE = 0;
    localparam int SLOT_PRG_BASE = 1;
    localparam int SLOT_CHR_CTL  = 2;
    localparam int SLOT_PRG_CTL  = 3;

    typedef enum logic {
        WIN_OPEN   = 1'b0,
        WIN_LOCKED = 1'b1
    } win_state_t;

endpackage

// File: rtl/mc_outer_regfile.sv
module mc_outer_regfile
    import mc_outer_bank_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int W       = OB_W,
    parameter int WIN_LO  = 'h6000,
    parameter int WIN_HI  = 'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      slot0,
    output logic [W-1:0]      slot1,
    output logic [W-1:0]      slot2,
    output logic [W-1:0]      slot3
);

    localparam logic [OB_IDX_W-1:0] LAST_IDX = OB_IDX_W'(OB_SLOTS - 1);

    win_state_t          st_q;
    win_state_t          st_d;
    logic [OB_IDX_W-1:0] idx_q;
    logic                in_win;
    logic                take;
    logic [W-1:0]        slot_q [OB_SLOTS];

    always_comb begin
        in_win = (int'(wr_addr) >= WIN_LO) && (int'(wr_addr) <= WIN_HI);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= WIN_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q)
            WIN_OPEN: begin
                take = wr_en && in_win;
                if (take && (idx_q == LAST_IDX) && wr_data[OB_LOCK_BIT]) begin
                    st_d = WIN_LOCKED;
                end
            end
            WIN_LOCKED: begin
                st_d = WIN_LOCKED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < OB_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (take && (idx_q == OB_IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign slot0 = slot_q[0];
    assign slot1 = slot_q[1];
    assign slot2 = slot_q[2];
    assign slot3 = slot_q[3];

    // R1: pointer steps by one after every taken write
    assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (idx_q == $past(idx_q) + 1'b1));

    // R2: a write outside the window leaves the pointer where it was
    assert_outside_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_win) |=> $stable(idx_q));

    // R3: the locked state holds and freezes the pointer
    assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WIN_LOCKED) |=> ((st_q == WIN_LOCKED) && $stable(idx_q)));

    // R4: reset clears the pointer and the lock
    assert_reset_clear_R4: assert property (@(posedge clk)
        !rst_n |=> ((idx_q == '0) && (st_q == WIN_OPEN)));

endmodule

// File: rtl/mc_chr_path.sv
module mc_chr_path
    import mc_outer_bank_pkg::*;
#(
    parameter int W = OB_W
) (
    input  logic [W-1:0] inner,
    input  logic [W-1:0] base,
    input  logic [W-1:0] ctl,
    output logic [W:0]   bank
);

    logic [OB_CHR_SEL_W-1:0] sel;
    logic [W-1:0]            keep;

    assign sel = ctl[OB_CHR_SEL_W-1:0];

    // Thermometer mask: bit i survives when i <= sel
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign keep[i] = (i <= int'(sel));
    end

    assign bank = {ctl[OB_CHR_HI], (inner & keep) | base};

endmodule

// File: rtl/mc_prg_path.sv
module mc_prg_path
    import mc_outer_bank_pkg::*;
#(
    parameter int W = OB_W
) (
    input  logic [W-1:0] inner,
    input  logic [W-1:0] base,
    input  logic [W-1:0] ctl,
    output logic [W-1:0] bank
);

    localparam int HI_W = W - OB_PRG_MSK_W;

    logic [W-1:0] keep;

    assign keep = {{HI_W{1'b0}}, ~ctl[OB_PRG_MSK_W-1:0]};
    assign bank = (inner & keep) | base;

endmodule

// File: rtl/mc_outer_bank.sv
module mc_outer_bank
    import mc_outer_bank_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int W      = OB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [W-1:0]      cpu_data,
    input  logic [W-1:0]      prg_in,
    input  logic [W-1:0]      chr_in,
    output logic [W-1:0]      prg_out,
    output logic [W:0]        chr_out
);

    logic [W-1:0] chr_base;
    logic [W-1:0] prg_base;
    logic [W-1:0] chr_ctl;
    logic [W-1:0] prg_ctl;

    mc_outer_regfile #(.ADDR_W(ADDR_W), .W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cpu_wr),
        .wr_addr(cpu_addr),
        .wr_data(cpu_data),
        .slot0  (chr_base),
        .slot1  (prg_base),
        .slot2  (chr_ctl),
        .slot3  (prg_ctl)
    );

    mc_chr_path #(.W(W)) u_chr (
        .inner(chr_in),
        .base (chr_base),
        .ctl  (chr_ctl),
        .bank (chr_out)
    );

    mc_prg_path #(.W(W)) u_prg (
        .inner(prg_in),
        .base (prg_base),
        .ctl  (prg_ctl),
        .bank (prg_out)
    );

    // R8: the final program bank always contains the slot 1 base
    assert_prg_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((prg_out & prg_base) == prg_base));

    // R6: character bank bit 8 tracks slot 2 bit 4, low byte holds the base
    assert_chr_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((chr_out[W] == chr_ctl[OB_CHR_HI]) && ((chr_out[W-1:0] & chr_base) == chr_base)));

endmodule

// File: tb/tb_mc_outer_bank.sv
module tb_mc_outer_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        cpu_wr;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic [7:0]  prg_in;
    logic [7:0]  chr_in;
    logic [7:0]  prg_out;
    logic [8:0]  chr_out;

    mc_outer_bank dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_wr  (cpu_wr),
        .cpu_addr(cpu_addr),
        .cpu_data(cpu_data),
        .prg_in  (prg_in),
        .chr_in  (chr_in),
        .prg_out (prg_out),
        .chr_out (chr_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [7:0] prg;
        logic [8:0] chr;
        string      tag;
    } exp_t;

    exp_t   sb_q[$];
    event   mon_ev;
    int     n_checks = 0;
    int     n_fail   = 0;
    bit     done     = 0;

    // Reference model of the outer registers
    logic [7:0] m_reg [4];
    int         m_idx;
    bit         m_lock;

    function automatic logic [7:0] exp_prg(logic [7:0] p);
        logic [7:0] msk;
        msk = (m_reg[3] & 8'h3F) ^ 8'h3F;
        return (p & msk) | m_reg[1];
    endfunction

    function automatic logic [8:0] exp_chr(logic [7:0] c);
        int n;
        int msk;
        n   = int'(m_reg[2] & 8'h07) + 1;
        msk = (1 << n) - 1;
        return {m_reg[2][4], (c & 8'(msk)) | m_reg[0]};
    endfunction

    // Monitor: pops each expected item and compares
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (prg_out !== e.prg || chr_out !== e.chr) begin
                    n_fail++;
                    $display("FAIL %s: prg_out=%h chr_out=%h expected prg=%h chr=%h",
                             e.tag, prg_out, chr_out, e.prg, e.chr);
                end
            end
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
        m_idx  = 0;
        m_lock = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic cpu_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_wr   = 1'b1;
        cpu_addr = a;
        cpu_data = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a >= 16'h6000 && a <= 16'h7FFF && !m_lock) begin
            m_reg[m_idx] = d;
            if (m_idx == 3 && d[6]) m_lock = 1;
            m_idx = (m_idx + 1) % 4;
        end
    endtask

    task automatic fill4(logic [7:0] d0, logic [7:0] d1, logic [7:0] d2, logic [7:0] d3);
        cpu_write(16'h6000, d0);
        cpu_write(16'h7FFF, d1);
        cpu_write(16'h6A5A, d2);
        cpu_write(16'h7001, d3);
    endtask

    // Driver: apply inner banks, push the expected item, wake the monitor
    task automatic probe(logic [7:0] p, logic [7:0] c, string tag);
        exp_t e;
        @(negedge clk);
        prg_in = p;
        chr_in = c;
        e.prg = exp_prg(p);
        e.chr = exp_chr(c);
        e.tag = tag;
        sb_q.push_back(e);
        #1;
        ->mon_ev;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        rst_n    = 1'b0;
        cpu_wr   = 1'b0;
        cpu_addr = 16'h0000;
        cpu_data = 8'h00;
        prg_in   = 8'h00;
        chr_in   = 8'h00;
        model_reset();
        do_reset();

        // R4: reset state
        probe(8'hFF, 8'hFF, "R4 reset all-ones");
        probe(8'hA5, 8'h5A, "R4 reset pattern");

        // R1 R5 R6 R7 R8: four sequential writes
        fill4(8'h40, 8'hC0, 8'h13, 8'h30);
        probe(8'hFF, 8'hFF, "R1 R6 R8 fill all-ones");
        probe(8'h00, 8'h00, "R6 R8 base only");
        probe(8'h3C, 8'h1E, "R5 R7 mask pattern");

        // R9: same-cycle response to new inner values
        probe(8'h0A, 8'h07, "R9 combinational a");
        probe(8'h05, 8'h0C, "R9 combinational b");

        // R2: writes outside the window are ignored; pointer still at 0
        cpu_write(16'h5FFF, 8'hEE);
        cpu_write(16'h8000, 8'hEE);
        probe(8'hFF, 8'hFF, "R2 outside writes no effect");
        cpu_write(16'h6000, 8'h02);
        probe(8'h00, 8'h00, "R2 R1 next write lands in slot 0");
        cpu_write(16'h6000, 8'h00);
        cpu_write(16'h6000, 8'h00);
        cpu_write(16'h6000, 8'h00);

        // R5: every character mask width
        for (int n = 0; n < 8; n++) begin
            fill4(8'h00, 8'h00, 8'(n), 8'h00);
            probe(8'hFF, 8'hFF, $sformatf("R5 chr mask sel=%0d", n));
        end

        // R7: program mask with each single bit cleared
        for (int b = 0; b < 6; b++) begin
            fill4(8'h00, 8'h00, 8'h07, 8'(1 << b));
            probe(8'hFF, 8'h00, $sformatf("R7 prg mask bit %0d", b));
        end

        // R3: lock, then further writes are ignored
        fill4(8'h05, 8'h20, 8'h12, 8'h41);
        probe(8'hFF, 8'hFF, "R3 locked config");
        fill4(8'hFF, 8'hFF, 8'hFF, 8'h00);
        cpu_write(16'h6000, 8'h80);
        probe(8'hFF, 8'hFF, "R3 writes after lock ignored");
        probe(8'h11, 8'h03, "R3 locked pattern");

        // R4: reset after lock reopens the window
        do_reset();
        probe(8'hFF, 8'hFF, "R4 reset after lock");
        cpu_write(16'h6000, 8'h08);
        probe(8'h00, 8'h00, "R4 R1 write accepted after reset");

        @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule